// File: doc/BRIEF.md
# Video Memory Access Slot Scheduler

This block divides every scanline of video memory bandwidth into access slots of four serial clocks each. Since the serial clock runs at twice the pixel rate, one slot spans two output pixels. Each slot goes to one client: background layer mapping fetch, background layer pattern fetch, sprite mapping fetch, sprite pattern fetch, external (CPU) access, or memory refresh. The memory sequencer downstream reads a one-cycle strobe at the start of each slot, together with a slot-type code and a one-hot grant. It then runs the matching access for the following four serial clocks.

The slot table is not held in a ROM. Small functions compute it from the slot index and a few parameters. Narrow mode gives 171 slots per line and wide mode gives 210. A display line opens with a run of sprite pattern slots, then a series of eight-slot layer groups, then a short external tail. Refresh slots recur at a fixed pitch and take priority over every other owner. On blanked lines, and while the display is switched off, every slot that is not a refresh slot becomes an external slot. Sprite-owned slots are never handed to external access, even when no sprites remain for the line.

Top module: `vmem_slot_sched`

## Requirements
- R1: A slot lasts four clocks on which `sc_en` is high. `slot_start` pulses for one cycle, in the clock cycle that follows the enabled clock that opens a slot. An enabled clock with `line_start` high opens slot 0 at once, even in the middle of a slot.
- R2: A line holds 171 slots in narrow mode (`wide`=0) and 210 slots in wide mode (`wide`=1). The index wraps to 0 after the last slot.
- R3: A slot whose index modulo 42 equals 41 is a refresh slot (type code 6) on every kind of line. This gives 4 refresh slots in narrow mode and 5 in wide mode.
- R4: On a display line, slots 0 to 31 (narrow) or 0 to 39 (wide) are sprite pattern slots (type code 4).
- R5: After the sprite pattern run come 17 (narrow) or 21 (wide) layer groups of eight slots. Within a group, offsets 0 and 3 are layer mapping (code 1), offsets 1, 2, 4 and 5 are layer pattern (code 2), offset 6 is sprite mapping (code 3) and offset 7 is external (code 5). The first group is the extra scroll block and is always fetched.
- R6: On a display line, the slots after the last layer group are external (code 5). With refresh included, a narrow line has 33 layer mapping, 66 layer pattern, 17 sprite mapping, 32 sprite pattern, 19 external and 4 refresh slots. A wide line has 41, 82, 21, 40, 21 and 5.
- R7: When `vblank` is high or `disp_en` is low, every slot that is not a refresh slot is external. This gives 167 external slots in narrow mode and 205 in wide mode.
- R8: When `spr_more` is low at the start of a sprite mapping or sprite pattern slot, that slot is idle. Its type code is 0 and its grant is all zeros, and it is never external.
- R9: A line with `vblank` low and `disp_en` high gets the full display pattern, even when it directly follows a blanked line. This covers the line before the first visible line.
- R10: `slot_grant` is all zeros for type 0. For any other type code c, only bit c-1 is set.
- R11: `wide`, `vblank`, `disp_en` and `spr_more` are sampled only on the clock that opens a slot. `slot_type` and `slot_grant` hold steady between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sc_en | input | 1 | Serial clock enable, one per serial clock |
| line_start | input | 1 | With sc_en, opens slot 0 of a new line |
| wide | input | 1 | 1 selects the wide line (210 slots), 0 the narrow line (171 slots) |
| vblank | input | 1 | Vertical blanking line |
| disp_en | input | 1 | Display enable |
| spr_more | input | 1 | Sprites remain to be fetched on this line |
| slot_start | output | 1 | One-cycle strobe at the start of each slot |
| slot_grant | output | 6 | One-hot grant: layer map, layer pattern, sprite map, sprite pattern, external, refresh (bit 0 upward) |
| slot_type | output | 3 | Slot type code of the current slot |

## Verification
The bench builds the block with its default parameters: 171 and 210 slots, 32 and 40 sprite pattern slots, 17 and 21 layer groups, and a refresh pitch of 42 at offset 41. With these values, refresh slots land on a layer pattern slot, a layer mapping slot and a group's external slot. In wide mode a refresh slot also lands on the very last slot of the line. So the per-line totals show whether refresh priority holds against every kind of owner. Lines run with `sc_en` high on every cycle and on every second cycle, and one run restarts a line in the middle of a slot, to test the strobe position and the sampling of the mode inputs.

// File: rtl/vsched_pkg.sv
`timescale 1ns/1ps
package vsched_pkg;

  typedef enum logic [2:0] {
    SL_IDLE = 3'd0,
    SL_LMAP = 3'd1,
    SL_LPAT = 3'd2,
    SL_SMAP = 3'd3,
    SL_SPAT = 3'd4,
    SL_EXT  = 3'd5,
    SL_REF  = 3'd6
  } slot_kind_e;

  localparam int N_CLIENT = 6;
  localparam int GRP_LEN  = 8;

  // Owner of a slot by its offset inside an eight-slot layer group.
  function automatic slot_kind_e group_owner(int unsigned off);
    case (off)
      0, 3:       return SL_LMAP;
      1, 2, 4, 5: return SL_LPAT;
      6:          return SL_SMAP;
      default:    return SL_EXT;
    endcase
  endfunction

  function automatic logic on_refresh(int unsigned idx, int unsigned pitch,
                                      int unsigned roff);
    return (idx % pitch) == roff;
  endfunction

  // Full slot decision; refresh first, then blanking, then the display layout.
  function automatic slot_kind_e slot_owner(int unsigned idx, int unsigned nspat,
                                            int unsigned ngrp, int unsigned pitch,
                                            int unsigned roff, logic blank,
                                            logic spr_more);
    slot_kind_e k;
    if (on_refresh(idx, pitch, roff))          k = SL_REF;
    else if (blank)                            k = SL_EXT;
    else if (idx < nspat)                      k = spr_more ? SL_SPAT : SL_IDLE;
    else if (idx < nspat + ngrp * GRP_LEN) begin
      k = group_owner((idx - nspat) % GRP_LEN);
      if (k == SL_SMAP && !spr_more)           k = SL_IDLE;
    end
    else                                       k = SL_EXT;
    return k;
  endfunction

  // True when the position belongs to sprite fetch on a display line.
  function automatic logic sprite_owned(int unsigned idx, int unsigned nspat,
                                        int unsigned ngrp, int unsigned pitch,
                                        int unsigned roff, logic blank);
    logic r;
    r = 1'b0;
    if (!blank && !on_refresh(idx, pitch, roff)) begin
      if (idx < nspat) r = 1'b1;
      else if (idx < nspat + ngrp * GRP_LEN)
        r = (group_owner((idx - nspat) % GRP_LEN) == SL_SMAP);
    end
    return r;
  endfunction

endpackage

// File: rtl/vsched_timer.sv
`timescale 1ns/1ps
module vsched_timer #(
  parameter int N_NARROW = 171,
  parameter int N_WIDE   = 210,
  parameter int IDX_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sc_en,
  input  logic             line_start,
  input  logic             wide,
  output logic [IDX_W-1:0] cur_idx,
  output logic             cur_first
);
  localparam logic [IDX_W-1:0] LAST_N = IDX_W'(N_NARROW - 1);
  localparam logic [IDX_W-1:0] LAST_W = IDX_W'(N_WIDE - 1);

  logic [1:0]       ph_q, cur_ph;
  logic [IDX_W-1:0] idx_q, last;

  always_comb begin
    last = wide ? LAST_W : LAST_N;
    if (line_start) begin
      cur_ph  = 2'd0;
      cur_idx = '0;
    end else if (ph_q == 2'd3) begin
      cur_ph  = 2'd0;
      cur_idx = (idx_q >= last) ? '0 : idx_q + 1'b1;
    end else begin
      cur_ph  = ph_q + 2'd1;
      cur_idx = idx_q;
    end
    cur_first = sc_en && (cur_ph == 2'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 2'd3;
      idx_q <= LAST_W;
    end else if (sc_en) begin
      ph_q  <= cur_ph;
      idx_q <= cur_idx;
    end
  end
endmodule

// File: rtl/vsched_classify.sv
`timescale 1ns/1ps
module vsched_classify
  import vsched_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int SPAT_N    = 32,
  parameter int SPAT_W    = 40,
  parameter int GRP_N     = 17,
  parameter int GRP_W     = 21,
  parameter int REF_PITCH = 42,
  parameter int REF_OFF   = 41
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             wide,
  input  logic             blank,
  input  logic             spr_more,
  output slot_kind_e       kind,
  output logic             spr_pos
);
  int unsigned nspat, ngrp;

  always_comb begin
    nspat   = wide ? SPAT_W : SPAT_N;
    ngrp    = wide ? GRP_W  : GRP_N;
    kind    = slot_owner(32'(idx), nspat, ngrp, REF_PITCH, REF_OFF, blank, spr_more);
    spr_pos = sprite_owned(32'(idx), nspat, ngrp, REF_PITCH, REF_OFF, blank);
  end
endmodule

// File: rtl/vmem_slot_sched.sv
`timescale 1ns/1ps
module vmem_slot_sched
  import vsched_pkg::*;
#(
  parameter int SLOTS_NARROW = 171,
  parameter int SLOTS_WIDE   = 210,
  parameter int SPAT_NARROW  = 32,
  parameter int SPAT_WIDE    = 40,
  parameter int GRP_NARROW   = 17,
  parameter int GRP_WIDE     = 21,
  parameter int REF_PITCH    = 42,
  parameter int REF_OFF      = 41
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sc_en,
  input  logic                line_start,
  input  logic                wide,
  input  logic                vblank,
  input  logic                disp_en,
  input  logic                spr_more,
  output logic                slot_start,
  output logic [N_CLIENT-1:0] slot_grant,
  output logic [2:0]          slot_type
);
  localparam int IDX_W = $clog2(SLOTS_WIDE);

  logic [IDX_W-1:0]    cur_idx;
  logic                cur_first;
  logic                blank_now;
  logic                spr_pos;
  slot_kind_e          kind;
  logic [N_CLIENT-1:0] grant_next;

  assign blank_now = vblank | ~disp_en;

  vsched_timer #(
    .N_NARROW (SLOTS_NARROW),
    .N_WIDE   (SLOTS_WIDE),
    .IDX_W    (IDX_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sc_en      (sc_en),
    .line_start (line_start),
    .wide       (wide),
    .cur_idx    (cur_idx),
    .cur_first  (cur_first)
  );

  vsched_classify #(
    .IDX_W     (IDX_W),
    .SPAT_N    (SPAT_NARROW),
    .SPAT_W    (SPAT_WIDE),
    .GRP_N     (GRP_NARROW),
    .GRP_W     (GRP_WIDE),
    .REF_PITCH (REF_PITCH),
    .REF_OFF   (REF_OFF)
  ) u_class (
    .idx      (cur_idx),
    .wide     (wide),
    .blank    (blank_now),
    .spr_more (spr_more),
    .kind     (kind),
    .spr_pos  (spr_pos)
  );

  for (genvar b = 0; b < N_CLIENT; b++) begin : g_grant
    assign grant_next[b] = (kind == slot_kind_e'(3'(b + 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_start <= 1'b0;
      slot_grant <= '0;
      slot_type  <= SL_IDLE;
    end else begin
      slot_start <= cur_first;
      if (cur_first) begin
        slot_grant <= grant_next;
        slot_type  <= kind;
      end
    end
  end
endmodule

// File: rtl/vsched_checker.sv
`timescale 1ns/1ps
module vsched_checker
  import vsched_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                sc_en,
  input logic                slot_start,
  input logic [N_CLIENT-1:0] slot_grant,
  input logic [2:0]          slot_type,
  input logic                blank_now,
  input logic                spr_pos
);
  assert_strobe_follows_sc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> $past(sc_en));

  assert_blank_no_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start && $past(blank_now) |-> (slot_type == SL_EXT || slot_type == SL_REF));

  assert_sprite_not_external_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start && $past(spr_pos) |-> slot_type != SL_EXT);

  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_grant));

  assert_grant_matches_type_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_type != SL_IDLE) |-> slot_grant[slot_type - 3'd1]);

  assert_idle_no_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_type == SL_IDLE) |-> slot_grant == '0);

  assert_hold_between_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |-> $stable(slot_type) && $stable(slot_grant));
endmodule

bind vmem_slot_sched vsched_checker u_chk (.*);

// File: tb/sim_vmem_slot_sched.sv
`timescale 1ns/1ps
module sim_vmem_slot_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sc_en = 1'b0, line_start = 1'b0, wide = 1'b0;
  logic       vblank = 1'b0, disp_en = 1'b1, spr_more = 1'b1;
  logic       slot_start;
  logic [5:0] slot_grant;
  logic [2:0] slot_type;

  int total = 0, bad = 0;
  int cnt [0:7];
  int nstarts, gbad;
  logic [2:0] seen [0:255];

  always #4 clk = ~clk;

  vmem_slot_sched u0 (
    .clk(clk), .rst_n(rst_n), .sc_en(sc_en), .line_start(line_start),
    .wide(wide), .vblank(vblank), .disp_en(disp_en), .spr_more(spr_more),
    .slot_start(slot_start), .slot_grant(slot_grant), .slot_type(slot_type)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected totals per line: codes 0 idle,1 lmap,2 lpat,3 smap,4 spat,5 ext,6 ref.
  function automatic int expect_cnt(int kind, bit w, bit blank, bit spr);
    int n, r, v;
    n = w ? 210 : 171;
    r = w ? 5 : 4;
    if (blank) return (kind == 6) ? r : (kind == 5) ? n - r : 0;
    case (kind)
      1: v = w ? 41 : 33;
      2: v = w ? 82 : 66;
      3: v = spr ? (w ? 21 : 17) : 0;
      4: v = spr ? (w ? 40 : 32) : 0;
      5: v = w ? 21 : 19;
      6: v = r;
      0: v = spr ? 0 : (w ? 61 : 49);
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic observe();
    logic [5:0] eg;
    if (slot_start) begin
      cnt[slot_type]++;
      if (nstarts < 256) seen[nstarts] = slot_type;
      eg = (slot_type == 3'd0) ? 6'd0 : (6'd1 << (slot_type - 3'd1));
      if (eg != slot_grant) gbad++;
      nstarts++;
    end
  endtask

  task automatic step(input logic sc, input logic ls);
    @(negedge clk);
    observe();
    sc_en = sc;
    line_start = ls;
  endtask

  task automatic run_line(input bit w, input bit vb, input bit de, input bit sm,
                          input bit gap, input string tag);
    int n;
    bit blank;
    n = w ? 210 : 171;
    blank = vb || !de;
    for (int k = 0; k < 8; k++) cnt[k] = 0;
    nstarts = 0;
    gbad = 0;
    wide = w; vblank = vb; disp_en = de; spr_more = sm;
    for (int s = 0; s < n * 4; s++) begin
      step(1'b1, s == 0);
      if (gap) step(1'b0, 1'b0);
    end
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk(nstarts == n, {"R2 slots per line ", tag}, nstarts, n);
    chk(gbad == 0, {"R10 grant/type ", tag}, gbad, 0);
    chk(cnt[6] == expect_cnt(6, w, blank, sm), {"R3 refresh ", tag}, cnt[6], expect_cnt(6, w, blank, sm));
    chk(cnt[5] == expect_cnt(5, w, blank, sm), {"R6/R7 external ", tag}, cnt[5], expect_cnt(5, w, blank, sm));
    chk(cnt[4] == expect_cnt(4, w, blank, sm), {"R4 sprite pattern ", tag}, cnt[4], expect_cnt(4, w, blank, sm));
    chk(cnt[3] == expect_cnt(3, w, blank, sm), {"R5 sprite map ", tag}, cnt[3], expect_cnt(3, w, blank, sm));
    chk(cnt[1] == expect_cnt(1, w, blank, sm), {"R5 layer map ", tag}, cnt[1], expect_cnt(1, w, blank, sm));
    chk(cnt[2] == expect_cnt(2, w, blank, sm), {"R5 layer pattern ", tag}, cnt[2], expect_cnt(2, w, blank, sm));
    chk(cnt[0] == expect_cnt(0, w, blank, sm), {"R8 idle ", tag}, cnt[0], expect_cnt(0, w, blank, sm));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(slot_start == 1'b0, "R1 reset strobe", int'(slot_start), 0);
    chk(slot_grant == 6'd0, "R10 reset grant", int'(slot_grant), 0);
    chk(slot_type == 3'd0, "R10 reset type", int'(slot_type), 0);
  endtask

  task automatic t_active_narrow();
    run_line(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "narrow active");
    chk(seen[0] == 3'd4, "R4 slot0 sprite pattern", int'(seen[0]), 4);
    chk(seen[31] == 3'd4, "R4 slot31 sprite pattern", int'(seen[31]), 4);
    chk(seen[32] == 3'd1, "R5 scroll group map", int'(seen[32]), 1);
    chk(seen[33] == 3'd2 && seen[34] == 3'd2, "R5 scroll group pattern", int'(seen[34]), 2);
    chk(seen[38] == 3'd3, "R5 sprite map offset", int'(seen[38]), 3);
    chk(seen[41] == 3'd6, "R3 refresh at 41", int'(seen[41]), 6);
    chk(seen[170] == 3'd5, "R6 tail external", int'(seen[170]), 5);
  endtask

  task automatic t_active_wide_halfrate();
    run_line(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "wide active half-rate R1");
    chk(seen[39] == 3'd4, "R4 wide slot39", int'(seen[39]), 4);
    chk(seen[209] == 3'd6, "R3 wide last slot refresh", int'(seen[209]), 6);
  endtask

  task automatic t_blanking();
    run_line(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "narrow vblank R7");
    run_line(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "wide vblank R7");
    run_line(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "wide display off R7");
  endtask

  task automatic t_sprites_exhausted();
    run_line(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "narrow no sprites R8");
    chk(seen[0] == 3'd0, "R8 sprite pattern idle", int'(seen[0]), 0);
    chk(seen[38] == 3'd0, "R8 sprite map idle", int'(seen[38]), 0);
  endtask

  task automatic t_first_line();
    run_line(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "wide last blank line R9");
    run_line(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "wide line before first R9");
  endtask

  task automatic t_strobe_timing();
    wide = 1'b0; vblank = 1'b0; disp_en = 1'b1; spr_more = 1'b1;
    @(negedge clk); sc_en = 1'b1; line_start = 1'b1;
    @(negedge clk);
    chk(slot_start == 1'b1, "R1 strobe after line start", int'(slot_start), 1);
    chk(slot_type == 3'd4, "R1 slot0 type", int'(slot_type), 4);
    line_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(slot_start == 1'b0, "R1 no strobe mid-slot", int'(slot_start), 0);
    end
    @(negedge clk);
    chk(slot_start == 1'b1, "R1 strobe on fifth clock", int'(slot_start), 1);
    line_start = 1'b1;
    @(negedge clk);
    chk(slot_start == 1'b1 && slot_type == 3'd4, "R1 restart mid-line", int'(slot_type), 4);
    line_start = 1'b0;
    vblank = 1'b1;
    @(negedge clk);
    chk(slot_type == 3'd4, "R11 type held mid-slot", int'(slot_type), 4);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(slot_start == 1'b1 && slot_type == 3'd5, "R11 vblank taken at next slot", int'(slot_type), 5);
    sc_en = 1'b0;
    vblank = 1'b0;
  endtask

  initial begin
    #1600000;
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_strobe_timing();
    t_active_narrow();
    t_active_wide_halfrate();
    t_blanking();
    t_sprites_exhausted();
    t_first_line();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule